// File: doc/BRIEF.md
# Unit-Stride Vector Load Line Distributor

This block carries out a unit-stride vector load of 32-bit words for a lane-parallel vector unit. A load begins with a start pulse that carries a base byte address and a run-time vector length. The block then splits the load into whole data-cache line reads. Each returned line is spread across the lanes' register-file write ports, so that element e reaches lane e. Element e is the word at byte address base + 4·e.

Line reads use a valid/ready request channel that carries a line-aligned byte address. Data comes back on a valid/ready response channel that carries one whole line. The request holds its address and its valid until `req_ready` accepts it. The response is taken only on a cycle where both `rsp_valid` and `rsp_ready` are high. `rsp_ready` is high only while a line is awaited. The lane write ports have no back-pressure.

Two limits govern the write ports. A crossbar with `PORTS` outputs writes at most that many lanes in one cycle. A line that has more usable words than that is drained over several cycles. The next line is requested only once the current one is used up. A one-cycle `done` pulse closes each load.

Top module: `vload_distrib`

## Requirements
- R1: After reset, no lane write enable, `req_valid`, `rsp_ready` or `done` is high.
- R2: Each line request carries the line-aligned byte address (low log2(LINE_WORDS)+2 bits zero) of the lowest element not yet written. Successive requests advance by one line.
- R3: Element e is written to lane e with the word at byte address base + 4·e. Word i of a line is `rsp_data[i*32 +: 32]`, where i is bits [log2(LINE_WORDS)+1:2] of the word's byte address.
- R4: When the base is not line-aligned, the first line supplies words only from the base's word offset upward, starting at lane 0.
- R5: In any cycle at most `PORTS` lanes are written. They are contiguous, and they begin at the lowest lane not yet written, so lanes fill in ascending order.
- R6: No line request is raised in a cycle with a lane write. A new request comes only after every usable word of the current line has been written.
- R7: `done` is high for exactly one cycle, in the cycle after the last lane write. With a vector length of 0, `done` is high in the cycle after the start is taken, and no line is requested.
- R8: Lanes at or above the effective vector length are never written. A requested length above `LANES` is treated as `LANES`.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid` and `req_addr` hold steady on the next cycle.
- R10: A start pulse that arrives while a load is in progress is ignored. The running load's writes and requests are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load; taken only when idle |
| base_addr | input | ADDR_W | Word-aligned byte address of element 0 |
| vlen | input | $clog2(LANES+1) | Requested vector length |
| req_valid | output | 1 | Line request valid |
| req_ready | input | 1 | Line request accepted |
| req_addr | output | ADDR_W | Line-aligned byte address |
| rsp_valid | input | 1 | Line data valid |
| rsp_ready | output | 1 | Block is waiting for line data |
| rsp_data | input | LINE_WORDS*WORD_W | Line words, word 0 lowest |
| lane_we | output | LANES | Per-lane write enable |
| lane_data | output | LANES*WORD_W | Per-lane write data, lane 0 lowest |
| done | output | 1 | One-cycle load-complete pulse |

## Verification
The assertions assume three things about the inputs:
- `base_addr` is word-aligned whenever a start is taken.
- The memory side returns exactly one response for each accepted request.
- No response is offered before its request has been accepted.

The bench's memory responder keeps to these assumptions. It accepts a request after a random delay, answers only after that acceptance, and holds `rsp_valid` until the handshake completes. Every base address in the stimulus is a multiple of four. Loads cover:
- aligned and unaligned bases;
- lengths of 0, 1, partial and full;
- a length above the lane count;
- a second start while busy.

// File: rtl/vload_pkg.sv
package vload_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_WAIT  = 3'd2,
    ST_DRAIN = 3'd3,
    ST_FIN   = 3'd4
  } vl_state_t;
endpackage

// File: rtl/vload_seq.sv
module vload_seq
  import vload_pkg::*;
#(
  parameter int LANES      = 16,
  parameter int LINE_WORDS = 4,
  parameter int PORTS      = 2,
  parameter int ADDR_W     = 32,
  localparam int EW = $clog2(LANES + 1),
  localparam int WI = $clog2(LINE_WORDS + 1),
  localparam int OB = $clog2(LINE_WORDS),
  localparam int LB = OB + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [EW-1:0]     vlen,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  output logic              capture,
  output logic              drain,
  output logic [EW-1:0]     elem,
  output logic [WI-1:0]     widx,
  output logic [WI-1:0]     step,
  output logic [EW-1:0]     eff_len,
  output logic              done
);
  vl_state_t            state;
  logic [ADDR_W-3:0]    base_w;
  logic [ADDR_W-3:0]    cur_w;
  logic [OB-1:0]        cur_off;
  int                   room, left, kk;

  // word address of the lowest element still to be written
  assign cur_w    = base_w + (ADDR_W-2)'(elem);
  assign cur_off  = cur_w[OB-1:0];
  assign req_addr = {cur_w[ADDR_W-3:OB], {LB{1'b0}}};

  assign req_valid = (state == ST_REQ);
  assign rsp_ready = (state == ST_WAIT);
  assign capture   = rsp_valid && rsp_ready;
  assign drain     = (state == ST_DRAIN);
  assign done      = (state == ST_FIN);

  // lanes written this cycle: bounded by ports, line words left, elements left
  always_comb begin
    room = LINE_WORDS - int'(widx);
    left = int'(eff_len) - int'(elem);
    kk   = PORTS;
    if (room < kk) kk = room;
    if (left < kk) kk = left;
    if (kk < 0) kk = 0;
    step = kk[WI-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      base_w  <= '0;
      eff_len <= '0;
      elem    <= '0;
      widx    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          base_w  <= base_addr[ADDR_W-1:2];
          eff_len <= (vlen > EW'(LANES)) ? EW'(LANES) : vlen;
          elem    <= '0;
          state   <= (vlen == '0) ? ST_FIN : ST_REQ;
        end
        ST_REQ: if (req_ready) state <= ST_WAIT;
        ST_WAIT: if (rsp_valid) begin
          widx  <= WI'(cur_off);
          state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          elem <= elem + EW'(step);
          widx <= widx + step;
          if (elem + EW'(step) == eff_len) state <= ST_FIN;
          else if (widx + step == WI'(LINE_WORDS)) state <= ST_REQ;
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: the write pointer never passes the effective length
  p_elem_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    elem <= eff_len);
  // R9: a stalled request holds its address
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));
  // R4: a start is taken only with a word-aligned base
  p_base_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state == ST_IDLE) |-> (base_addr[1:0] == 2'b00));
  // R2: a drain cycle always moves at least one word
  p_drain_progress_r2: assert property (@(posedge clk) disable iff (!rst_n)
    drain |-> (step != '0));
endmodule

// File: rtl/vload_xbar.sv
module vload_xbar #(
  parameter int LANES      = 16,
  parameter int LINE_WORDS = 4,
  parameter int PORTS      = 2,
  parameter int WORD_W     = 32,
  localparam int EW = $clog2(LANES + 1),
  localparam int WI = $clog2(LINE_WORDS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         capture,
  input  logic [LINE_WORDS*WORD_W-1:0] rsp_data,
  input  logic                         drain,
  input  logic [EW-1:0]                elem,
  input  logic [WI-1:0]                widx,
  input  logic [WI-1:0]                step,
  output logic [LANES-1:0]             lane_we,
  output logic [LANES*WORD_W-1:0]      lane_data
);
  logic [WORD_W-1:0] line_q [LINE_WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINE_WORDS; i++) line_q[i] <= '0;
    end else if (capture) begin
      for (int i = 0; i < LINE_WORDS; i++) line_q[i] <= rsp_data[i*WORD_W +: WORD_W];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    int  rel;
    int  src;
    logic act;
    always_comb begin
      rel = l - int'(elem);
      src = int'(widx) + rel;
      act = drain && (rel >= 0) && (rel < int'(step));
    end
    assign lane_we[l] = act;
    assign lane_data[l*WORD_W +: WORD_W] =
      (act && src < LINE_WORDS) ? line_q[src] : '0;

    // R3: an active lane always picks a word inside the held line
    p_src_in_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
      act |-> (src >= 0 && src < LINE_WORDS));
  end
endmodule

// File: rtl/vload_distrib.sv
module vload_distrib #(
  parameter int LANES      = 16,
  parameter int LINE_WORDS = 4,
  parameter int PORTS      = 2,
  parameter int WORD_W     = 32,
  parameter int ADDR_W     = 32,
  localparam int EW = $clog2(LANES + 1),
  localparam int WI = $clog2(LINE_WORDS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [ADDR_W-1:0]            base_addr,
  input  logic [EW-1:0]                vlen,
  output logic                         req_valid,
  input  logic                         req_ready,
  output logic [ADDR_W-1:0]            req_addr,
  input  logic                         rsp_valid,
  output logic                         rsp_ready,
  input  logic [LINE_WORDS*WORD_W-1:0] rsp_data,
  output logic [LANES-1:0]             lane_we,
  output logic [LANES*WORD_W-1:0]      lane_data,
  output logic                         done
);
  logic          capture, drain;
  logic [EW-1:0] elem, eff_len;
  logic [WI-1:0] widx, step;

  vload_seq #(
    .LANES(LANES), .LINE_WORDS(LINE_WORDS), .PORTS(PORTS), .ADDR_W(ADDR_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .vlen(vlen),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .capture(capture),
    .drain(drain), .elem(elem), .widx(widx), .step(step),
    .eff_len(eff_len), .done(done)
  );

  vload_xbar #(
    .LANES(LANES), .LINE_WORDS(LINE_WORDS), .PORTS(PORTS), .WORD_W(WORD_W)
  ) u_xbar (
    .clk(clk), .rst_n(rst_n), .capture(capture), .rsp_data(rsp_data),
    .drain(drain), .elem(elem), .widx(widx), .step(step),
    .lane_we(lane_we), .lane_data(lane_data)
  );

  // R5: crossbar port limit
  p_port_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_we) <= PORTS);
  // R6: no request while lanes are being written
  p_no_req_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we != '0) |-> !req_valid);
  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: no write in the done cycle
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lane_we == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_vl_chk
    // R8: lanes at or above the effective length stay unwritten
    p_beyond_vl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lane_we[l] |-> (EW'(l) < eff_len));
  end
endmodule

// File: tb/vload_distrib_tb.sv
module vload_distrib_tb;
  localparam int LANES = 16, LW = 4, PORTS = 2, WW = 32, AW = 32;
  localparam int EW = $clog2(LANES + 1);

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] base_addr = '0;
  logic [EW-1:0] vlen = '0;
  logic req_valid, req_ready = 0, rsp_valid = 0, rsp_ready, done;
  logic [AW-1:0] req_addr;
  logic [LW*WW-1:0] rsp_data = '0;
  logic [LANES-1:0] lane_we;
  logic [LANES*WW-1:0] lane_data;

  int total = 0, fails = 0, nc = 0, last_evt = -10, done_cnt = 0;
  int exp_lane[$];
  logic [31:0] exp_data[$];
  logic [31:0] exp_line[$];

  always #10 clk = ~clk;

  vload_distrib #(.LANES(LANES), .LINE_WORDS(LW), .PORTS(PORTS), .WORD_W(WW), .ADDR_W(AW))
  u_dut (.clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .vlen(vlen),
         .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
         .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
         .lane_we(lane_we), .lane_data(lane_data), .done(done));

  function automatic logic [31:0] mw(logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[15:0]};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: push expected writes and line addresses, then start
  task automatic run_load(logic [31:0] base, int vl, bit poke);
    int eff = (vl > LANES) ? LANES : vl;
    int d0 = done_cnt;
    logic [31:0] ln, prev;
    prev = 32'hFFFF_FFFF;
    for (int e = 0; e < eff; e++) begin
      exp_lane.push_back(e);
      exp_data.push_back(mw(base + 32'(4*e)));
      ln = (base + 32'(4*e)) & ~32'(LW*4-1);
      if (ln != prev) exp_line.push_back(ln);
      prev = ln;
    end
    @(negedge clk);
    base_addr = base; vlen = EW'(vl); start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      // R10: second start during the load
      repeat (2) @(negedge clk);
      base_addr = 32'h900; vlen = EW'(16); start = 1;
      @(negedge clk);
      start = 0;
    end
    while (done_cnt == d0) @(negedge clk);
    chk(exp_lane.size() == 0, "R8 all expected lanes written", exp_lane.size(), 0);
    chk(exp_line.size() == 0, "R2 all lines requested", exp_line.size(), 0);
    repeat (4) @(negedge clk);
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && req_valid) begin
        logic [31:0] a;
        a = (exp_line.size() != 0) ? exp_line.pop_front() : 32'hDEAD_BEEF;
        chk(req_addr == a, "R2 line request address", req_addr, a);
        repeat ($urandom_range(0, 2)) @(negedge clk);
        req_ready = 1;
        @(posedge clk);
        @(negedge clk);
        req_ready = 0;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        for (int i = 0; i < LW; i++) rsp_data[i*WW +: WW] = mw(req_addr + 32'(4*i));
        rsp_valid = 1;
        while (!rsp_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        rsp_valid = 0;
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      nc++;
      if (start) last_evt = nc;
      if (lane_we != '0) begin
        chk($countones(lane_we) <= PORTS, "R5 ports per cycle", $countones(lane_we), PORTS);
        chk(!req_valid, "R6 no request during writes", req_valid, 0);
        last_evt = nc;
        for (int l = 0; l < LANES; l++) begin
          if (lane_we[l]) begin
            if (exp_lane.size() == 0) begin
              chk(0, "R8 unexpected lane write", l, 32'hFFFF);
            end else begin
              int el;
              logic [31:0] ed;
              el = exp_lane.pop_front();
              ed = exp_data.pop_front();
              chk(l == el, "R5 ascending lane order", l, el);
              chk(lane_data[l*WW +: WW] == ed, "R3 R4 lane data", lane_data[l*WW +: WW], ed);
            end
          end
        end
      end
      if (done) begin
        chk(nc == last_evt + 1, "R7 done timing", nc, last_evt + 1);
        done_cnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(lane_we == '0 && !req_valid && !rsp_ready && !done, "R1 reset outputs",
        {lane_we, req_valid, rsp_ready, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(lane_we == '0 && !req_valid && !done, "R1 idle after reset", {lane_we, req_valid, done}, 0);
    run_load(32'h100, 16, 0);   // aligned full load
    run_load(32'h108, 16, 0);   // R4 unaligned, five lines
    run_load(32'h20C, 5, 0);    // R4 last word of a line first
    run_load(32'h300, 0, 0);    // R7 zero length
    run_load(32'h404, 20, 0);   // R8 clamp to lane count
    run_load(32'h500, 3, 1);    // R10 start while busy ignored
    run_load(32'h60C, 1, 0);    // single element
    run_load(32'h704, 7, 0);    // partial, spans lines
    repeat (5) @(negedge clk);
    chk(lane_we == '0 && !req_valid, "R10 quiet after loads", {lane_we, req_valid}, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule